// File: doc/BRIEF.md
# Byte-Burst Serial Slave Port with Busy Line

This block is the slave side of a three-wire synchronous serial link. The master owns the serial clock and moves one byte per burst. Eight clock pulses carry eight bits from the master into the block and, during the same pulses, eight bits from the block back to the master. Both directions send the most significant bit first. Values wider than one byte go as several bursts, with the high byte first. The block only preserves the order in which bytes are loaded, so that order is up to local logic.

When a burst finishes, the block gives the received byte to local logic with a one-cycle valid strobe. It also drives a busy line high toward the master. The busy line stays high until local logic acknowledges the byte. At that acknowledge, local logic also loads the byte for the next burst and says whether that burst carries response data. In a response burst the master has to send the filler value 0xAA, and any other value raises an error flag. A separate active-low request line tells the master that internal status has changed. It drops when local logic reports a change and rises again when local logic reports that the master has read the status.

The serial clock and data are brought into the system clock with two-flop synchronizers. The system clock therefore has to run at least eight times the highest serial bit rate, which is 400 kHz.

Top module: `sbs_port`

## Requirements
- R1: After reset, rdy_o=0, req_n_o=1, sdo_o=0, overrun_o=0, filler_err_o=0 and rx_byte_o=0x00. The transmit register holds 0x00.
- R2: Eight accepted rising edges of sclk_i shift in one byte, first bit as bit 7. After the eighth edge, rx_byte_o holds the byte and rx_valid_o is high for exactly one system clock cycle.
- R3: rdy_o goes to 1 in the same cycle as rx_valid_o. It stays 1 until a cycle in which ack_i is high.
- R4: ack_i while rdy_o=1 clears rdy_o on the next cycle and loads tx_byte_i. Bit 7 of that byte is on sdo_o before the first rising edge of the next burst, and each falling edge inside the burst moves the next lower bit onto sdo_o.
- R5: ack_i while rdy_o=0 has no effect. rdy_o stays 0 and tx_byte_i is not loaded, so the next burst still sends the byte held before.
- R6: Rising edges of sclk_i while rdy_o=1 are ignored: they neither shift data nor advance the bit count. Each sets overrun_o, which stays 1 until reset.
- R7: A burst is a response burst when tx_mode_i was 1 at the acknowledge that loaded its byte. If such a burst receives any value other than 0xAA, filler_err_o is 1 from the end of that burst until the next acknowledge. Other bursts never set it.
- R8: A status_evt_i pulse drives req_n_o low on the next cycle. A status_read_i pulse drives it high again. If both pulses arrive in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master |
| rdy_o | output | 1 | Busy line, 1 while a received byte awaits acknowledge |
| req_n_o | output | 1 | Status-change request, active low |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new byte |
| ack_i | input | 1 | Local logic consumed the byte and loads the next one |
| tx_byte_i | input | 8 | Byte to send in the next burst, taken at ack |
| tx_mode_i | input | 1 | Next burst is response data, taken at ack |
| filler_err_o | output | 1 | Response burst received a non-filler byte |
| overrun_o | output | 1 | Sticky: clock pulse arrived while busy |
| status_evt_i | input | 1 | Internal status changed |
| status_read_i | input | 1 | Master has read the status |

## Verification
The hardest cases to reach from the ports are the ones where the master breaks the busy rule. In those cases clock pulses arrive while a byte is still unacknowledged, and the block has to drop them without losing bit alignment for the next burst. The bench holds acknowledge back, toggles the serial clock several times, and then runs a normal burst. Reading a clean new byte after that proves the ignored pulses did not advance the bit count. Response bursts are reached by acknowledging with the response flag set, then sending either the filler or a different value.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;

  // shift one bit into the low end, MSB-first framing
  function automatic byte_t shift_in(byte_t cur, logic b);
    return {cur[BYTE_W-2:0], b};
  endfunction

  // move the next transmit bit to the top, zero fill
  function automatic byte_t shift_out(byte_t cur);
    return {cur[BYTE_W-2:0], 1'b0};
  endfunction

  function automatic logic is_last_bit(logic [CNT_W-1:0] cnt);
    return cnt == CNT_W'(BYTE_W - 1);
  endfunction

  function automatic logic filler_bad(byte_t rx, byte_t fill);
    return rx != fill;
  endfunction
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdi_s_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned W = 2;
  logic [STAGES-1:0][W-1:0] chain;
  logic                     sclk_prev;
  logic                     sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain     <= '0;
      sclk_prev <= 1'b0;
    end else begin
      chain     <= {chain[STAGES-2:0], {sdi_i, sclk_i}};
      sclk_prev <= sclk_s;
    end
  end

  assign sclk_s  = chain[STAGES-1][0];
  assign sdi_s_o = chain[STAGES-1][1];
  assign rise_o  = sclk_s & ~sclk_prev;
  assign fall_o  = ~sclk_s & sclk_prev;
endmodule

// File: rtl/sbs_shift.sv
module sbs_shift
  import sbs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  busy_i,
  input  logic  sdi_s_i,
  input  logic  load_i,
  input  byte_t load_byte_i,
  output logic  sdo_o,
  output byte_t rx_byte_o,
  output logic  rx_valid_o,
  output logic  byte_done_o
);
  logic [CNT_W-1:0] cnt;
  byte_t            rx_sh;
  byte_t            tx_sh;
  logic             take_bit;
  logic             move_bit;

  assign take_bit    = rise_i & ~busy_i;
  assign move_bit    = fall_i & ~busy_i & (cnt != '0);
  assign byte_done_o = take_bit & is_last_bit(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      rx_sh      <= '0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= byte_done_o;
      if (take_bit) begin
        rx_sh <= shift_in(rx_sh, sdi_s_i);
        cnt   <= byte_done_o ? '0 : cnt + 1'b1;
        if (byte_done_o) rx_byte_o <= shift_in(rx_sh, sdi_s_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_sh <= '0;
    else if (load_i)   tx_sh <= load_byte_i;
    else if (move_bit) tx_sh <= shift_out(tx_sh);
  end

  assign sdo_o = tx_sh[BYTE_W-1];
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter byte_t FILLER = 8'hAA
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  byte_done_i,
  input  logic  rise_i,
  input  byte_t rx_next_i,
  input  logic  ack_i,
  input  logic  tx_mode_i,
  input  logic  status_evt_i,
  input  logic  status_read_i,
  output logic  rdy_o,
  output logic  load_o,
  output logic  filler_err_o,
  output logic  overrun_o,
  output logic  req_n_o
);
  logic resp_mode;

  assign load_o = ack_i & rdy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_o        <= 1'b0;
      resp_mode    <= 1'b0;
      filler_err_o <= 1'b0;
      overrun_o    <= 1'b0;
      req_n_o      <= 1'b1;
    end else begin
      if (byte_done_i)  rdy_o <= 1'b1;
      else if (load_o)  rdy_o <= 1'b0;

      if (load_o) resp_mode <= tx_mode_i;

      if (byte_done_i)  filler_err_o <= resp_mode & filler_bad(rx_next_i, FILLER);
      else if (load_o)  filler_err_o <= 1'b0;

      if (rise_i & rdy_o) overrun_o <= 1'b1;

      if (status_evt_i)       req_n_o <= 1'b0;
      else if (status_read_i) req_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sbs_port.sv
module sbs_port
  import sbs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter byte_t       FILLER      = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              rdy_o,
  output logic              req_n_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  input  logic              ack_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_mode_i,
  output logic              filler_err_o,
  output logic              overrun_o,
  input  logic              status_evt_i,
  input  logic              status_read_i
);
  logic  sdi_s;
  logic  rise_ev;
  logic  fall_ev;
  logic  byte_done;
  logic  load_ev;
  byte_t rx_next;

  sbs_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .sdi_s_o(sdi_s), .rise_o(rise_ev), .fall_o(fall_ev)
  );

  sbs_shift shift_i (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_ev), .fall_i(fall_ev),
    .busy_i(rdy_o), .sdi_s_i(sdi_s), .load_i(load_ev),
    .load_byte_i(tx_byte_i), .sdo_o(sdo_o), .rx_byte_o(rx_byte_o),
    .rx_valid_o(rx_valid_o), .byte_done_o(byte_done)
  );

  // byte the filler check sees: current shift contents plus the last bit
  assign rx_next = {shift_i.rx_sh[BYTE_W-2:0], sdi_s};

  sbs_ctrl #(.FILLER(FILLER)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .byte_done_i(byte_done), .rise_i(rise_ev),
    .rx_next_i(rx_next), .ack_i(ack_i), .tx_mode_i(tx_mode_i),
    .status_evt_i(status_evt_i), .status_read_i(status_read_i),
    .rdy_o(rdy_o), .load_o(load_ev), .filler_err_o(filler_err_o),
    .overrun_o(overrun_o), .req_n_o(req_n_o)
  );
endmodule

// File: rtl/sbs_port_chk.sv
module sbs_port_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy_o,
  input logic ack_i,
  input logic rx_valid_o,
  input logic overrun_o,
  input logic filler_err_o,
  input logic req_n_o,
  input logic status_evt_i,
  input logic status_read_i,
  input logic rise_ev,
  input logic byte_done
);
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  assert_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> rdy_o);
  assert_rdy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> rx_valid_o);
  assert_rdy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !ack_i) |=> rdy_o);
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && ack_i) |=> !rdy_o);
  assert_idle_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_o && ack_i && !byte_done) |=> !rdy_o);
  assert_busy_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && rise_ev) |=> overrun_o);
  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);
  assert_filler_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    filler_err_o |-> rdy_o);
  assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_evt_i |=> !req_n_o);
  assert_req_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_read_i && !status_evt_i) |=> req_n_o);
endmodule

bind sbs_port sbs_port_chk chk_i (.*);

// File: tb/sbs_port_tb.sv
module sbs_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_i = 1'b0, sdi_i = 1'b0;
  logic       sdo_o, rdy_o, req_n_o, rx_valid_o, filler_err_o, overrun_o;
  logic [7:0] rx_byte_o;
  logic       ack_i = 1'b0, tx_mode_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic       status_evt_i = 1'b0, status_read_i = 1'b0;
  int         checks = 0, failures = 0, vcount = 0;
  localparam int HALF = 8;

  always #2 clk = ~clk;

  sbs_port dut_i (.*);

  always @(negedge clk) if (rx_valid_o) vcount++;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] mosi, output logic [7:0] miso);
    for (int i = 7; i >= 0; i--) begin
      sdi_i = mosi[i];
      wait_clk(HALF);
      miso[i] = sdo_o;
      sclk_i = 1'b1;
      wait_clk(HALF);
      sclk_i = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic do_ack(logic [7:0] b, logic mode);
    tx_byte_i = b; tx_mode_i = mode; ack_i = 1'b1;
    wait_clk(1);
    ack_i = 1'b0;
    wait_clk(2);
  endtask

  task automatic t_reset;
    chk("R1 rdy", {7'd0, rdy_o}, 8'd0);
    chk("R1 req_n", {7'd0, req_n_o}, 8'd1);
    chk("R1 sdo", {7'd0, sdo_o}, 8'd0);
    chk("R1 overrun", {7'd0, overrun_o}, 8'd0);
    chk("R1 filler", {7'd0, filler_err_o}, 8'd0);
    chk("R1 rx_byte", rx_byte_o, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] m;
    int v0 = vcount;
    send_byte(8'h3C, m);
    chk("R1 tx reset byte", m, 8'h00);
    chk("R2 rx byte", rx_byte_o, 8'h3C);
    chk("R2 one strobe", 8'(vcount - v0), 8'd1);
    chk("R3 busy", {7'd0, rdy_o}, 8'd1);
    wait_clk(40);
    chk("R3 busy held", {7'd0, rdy_o}, 8'd1);
    do_ack(8'hA5, 1'b0);
    chk("R4 ack clears", {7'd0, rdy_o}, 8'd0);
    chk("R4 first bit", {7'd0, sdo_o}, 8'd1);
    send_byte(8'h81, m);
    chk("R4 tx byte", m, 8'hA5);
    chk("R2 rx second", rx_byte_o, 8'h81);
  endtask

  task automatic t_idle_ack;
    logic [7:0] m;
    do_ack(8'h5A, 1'b0);
    do_ack(8'hFF, 1'b1);
    chk("R5 rdy stays low", {7'd0, rdy_o}, 8'd0);
    send_byte(8'h00, m);
    chk("R5 tx not reloaded", m, 8'h5A);
    chk("R5 no response flag", {7'd0, filler_err_o}, 8'd0);
  endtask

  task automatic t_filler;
    logic [7:0] m;
    do_ack(8'h12, 1'b1);
    send_byte(8'hAA, m);
    chk("R7 filler ok", {7'd0, filler_err_o}, 8'd0);
    chk("R7 response byte", m, 8'h12);
    do_ack(8'h34, 1'b1);
    send_byte(8'h55, m);
    chk("R7 filler bad", {7'd0, filler_err_o}, 8'd1);
    do_ack(8'h00, 1'b0);
    chk("R7 cleared at ack", {7'd0, filler_err_o}, 8'd0);
    send_byte(8'h55, m);
    chk("R7 plain burst", {7'd0, filler_err_o}, 8'd0);
  endtask

  task automatic t_overrun;
    logic [7:0] m;
    int v0;
    chk("R6 overrun clear", {7'd0, overrun_o}, 8'd0);
    v0 = vcount;
    sdi_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_clk(HALF); sclk_i = 1'b1; wait_clk(HALF); sclk_i = 1'b0;
    end
    wait_clk(HALF);
    chk("R6 overrun set", {7'd0, overrun_o}, 8'd1);
    chk("R6 rx unchanged", rx_byte_o, 8'h55);
    chk("R6 no strobe", 8'(vcount - v0), 8'd0);
    do_ack(8'hC3, 1'b0);
    send_byte(8'h96, m);
    chk("R6 alignment kept", rx_byte_o, 8'h96);
    chk("R6 tx intact", m, 8'hC3);
    chk("R6 sticky", {7'd0, overrun_o}, 8'd1);
  endtask

  task automatic t_req;
    status_evt_i = 1'b1; wait_clk(1); status_evt_i = 1'b0; wait_clk(1);
    chk("R8 drop", {7'd0, req_n_o}, 8'd0);
    wait_clk(20);
    chk("R8 held", {7'd0, req_n_o}, 8'd0);
    status_read_i = 1'b1; wait_clk(1); status_read_i = 1'b0; wait_clk(1);
    chk("R8 release", {7'd0, req_n_o}, 8'd1);
    status_evt_i = 1'b1; status_read_i = 1'b1; wait_clk(1);
    status_evt_i = 1'b0; status_read_i = 1'b0; wait_clk(1);
    chk("R8 event wins", {7'd0, req_n_o}, 8'd0);
    status_read_i = 1'b1; wait_clk(1); status_read_i = 1'b0; wait_clk(1);
    chk("R8 release again", {7'd0, req_n_o}, 8'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(4);
    t_basic();
    t_idle_ack();
    t_filler();
    t_overrun();
    t_req();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule